// File: doc/BRIEF.md
# I2C Bus Condition and Interrupt Controller

This block is the control core of a two-wire serial bus interface. It watches the bus lines and recognises start and stop conditions, and from them it keeps a bus-busy flag. On request it produces its own start condition, clocks the bus with a simple fixed-rate SCL generator, and ends the transfer with a stop condition. Each SDA value it drives is presented a fixed number of cycles after SCL is pulled low, so the data hold time is met. Byte shifting, address matching and baud-rate division are left to neighbouring logic. The `tx_bit` input supplies the next SDA level.

A start request that arrives while the bus is taken is handled in one of two ways. When reservation is allowed, the request is held and issued once the bus becomes free. When reservation is disabled, the request is dropped and a sticky failure flag is set. An interrupt pulse marks either the falling edge of the 8th or of the 9th SCL clock of each byte, and, if enabled, a detected stop condition. After enabling, software can force the bus tracker to the released state with `bus_init`.

The generator is a state machine. Its states are IDLE (lines released), START (SDA low, SCL released), LOW (SCL low, SDA updated after the hold count), HIGH (SCL released), STOP_LO (both lines low) and STOP_HI (SCL released, SDA low). Its transitions are: IDLE→START when a start is pending and the bus is free; START→LOW after one half period; LOW→HIGH after one half period with no stop pending; LOW→STOP_LO after one half period with a stop pending; HIGH→LOW after one half period; STOP_LO→STOP_HI after one half period; STOP_HI→IDLE after one half period, which releases SDA.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: After reset, and within one clock of `enable` going low, `scl_oe`, `sda_oe`, `bus_busy`, `start_fail` and `irq` are all 0.
- R2: With the bus free, a `start_req` pulse makes the block assert `sda_oe` while `scl_oe` is 0. `scl_oe` follows HALF_CYC cycles later.
- R3: A `stop_req` during a transfer makes the block hold both lines low. It then releases SCL, and HALF_CYC cycles later it releases SDA while SCL stays released.
- R4: `bus_busy` goes to 1 after a start condition is seen on the lines, and to 0 after a stop condition is seen. This holds whether the block or another device drove the condition.
- R5: A `bus_init` pulse clears `bus_busy` without any condition on the lines.
- R6: When `resv_dis`=1 and the bus is busy, `start_req` produces no line activity, neither then nor after the bus frees. It sets `start_fail` to 1, which stays 1 until a `fail_clr` pulse.
- R7: When `resv_dis`=0 and the bus is busy, `start_req` is held. The block issues the start condition after the next stop condition frees the bus.
- R8: After a start, SCL rising edges are counted. With `irq_ninth`=0, `irq` pulses after the falling edge of the 8th clock of each byte; with `irq_ninth`=1 it pulses after the 9th. No pulse occurs at the other of the two.
- R9: With `stop_irq_en`=1, a detected stop condition raises `irq`. With `stop_irq_en`=0, a stop raises none.
- R10: When the block pulls SCL low, its SDA drive changes exactly HOLD_CYC cycles later, never earlier (HOLD_CYC ≥ 2, HOLD_CYC < HALF_CYC).
- R11: `irq` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, oversamples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; 0 clears all state |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| start_req | input | 1 | Start request strobe |
| stop_req | input | 1 | Stop request strobe |
| resv_dis | input | 1 | 1 = reject a start request while the bus is busy |
| bus_init | input | 1 | Strobe forcing the bus tracker to released |
| irq_ninth | input | 1 | 0 = interrupt on 8th clock fall, 1 = on 9th |
| stop_irq_en | input | 1 | Also interrupt on stop detection |
| fail_clr | input | 1 | Strobe clearing start_fail |
| tx_bit | input | 1 | Next SDA level to drive (1 = release) |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |
| bus_busy | output | 1 | Bus taken between start and stop |
| start_fail | output | 1 | Sticky: a start request was rejected |
| irq | output | 1 | Interrupt request pulse |

## Verification
A wrong bus-busy state shows up at the pins in two ways. A start request is held or rejected when it should not be, or the reverse. In either case the result appears on `sda_oe` or `start_fail` within a few cycles of the request. A wrong clock count makes `irq` arrive at a different SCL falling edge, which is visible within one byte. A generator stuck in the wrong state breaks the start, stop or hold ordering of `scl_oe` and `sda_oe` within one half period.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_LOW,
        ST_HIGH,
        ST_STOP_LO,
        ST_STOP_HI
    } gen_state_t;

    localparam int LINE_SCL = 1;
    localparam int LINE_SDA = 0;
    localparam int NLINES   = 2;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_cond_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic [NLINES-1:0] raw, m1, m2, prv;

    assign raw[LINE_SCL] = scl_in;
    assign raw[LINE_SDA] = sda_in;

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                m1[g]  <= 1'b1;
                m2[g]  <= 1'b1;
                prv[g] <= 1'b1;
            end else if (!enable) begin
                m1[g]  <= 1'b1;
                m2[g]  <= 1'b1;
                prv[g] <= 1'b1;
            end else begin
                m1[g]  <= raw[g];
                m2[g]  <= m1[g];
                prv[g] <= m2[g];
            end
        end
    end

    assign start_det = prv[LINE_SCL] & m2[LINE_SCL] & prv[LINE_SDA] & ~m2[LINE_SDA];
    assign stop_det  = prv[LINE_SCL] & m2[LINE_SCL] & ~prv[LINE_SDA] & m2[LINE_SDA];
    assign scl_rise  = ~prv[LINE_SCL] & m2[LINE_SCL];
    assign scl_fall  = prv[LINE_SCL] & ~m2[LINE_SCL];
endmodule

// File: rtl/i2c_bus_track.sv
module i2c_bus_track #(
    parameter int BYTE_CLKS = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start_det,
    input  logic stop_det,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic bus_init,
    input  logic irq_ninth,
    input  logic stop_irq_en,
    output logic bus_busy,
    output logic irq
);
    localparam int BW = $clog2(BYTE_CLKS + 1);

    logic [BW-1:0] clk_cnt;
    logic [BW-1:0] irq_at;

    assign irq_at = irq_ninth ? BW'(BYTE_CLKS) : BW'(BYTE_CLKS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_busy <= 1'b0;
            clk_cnt  <= '0;
            irq      <= 1'b0;
        end else if (!enable) begin
            bus_busy <= 1'b0;
            clk_cnt  <= '0;
            irq      <= 1'b0;
        end else begin
            if (bus_init)       bus_busy <= 1'b0;
            else if (start_det) bus_busy <= 1'b1;
            else if (stop_det)  bus_busy <= 1'b0;

            if (start_det)                                  clk_cnt <= '0;
            else if (scl_rise && bus_busy)                  clk_cnt <= clk_cnt + 1'b1;
            else if (scl_fall && clk_cnt == BW'(BYTE_CLKS)) clk_cnt <= '0;

            irq <= (scl_fall && bus_busy && clk_cnt == irq_at) ||
                   (stop_det && stop_irq_en);
        end
    end

    assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_busy_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start_det && !bus_init) |=> bus_busy);
    assert_free_on_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && stop_det && !start_det) |=> !bus_busy);
    assert_init_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_init |=> !bus_busy);
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
    import i2c_cond_pkg::*;
#(
    parameter int HALF_CYC = 10,
    parameter int HOLD_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start_req,
    input  logic stop_req,
    input  logic resv_dis,
    input  logic bus_busy,
    input  logic fail_clr,
    input  logic tx_bit,
    output logic scl_oe,
    output logic sda_oe,
    output logic start_fail
);
    localparam int CW = $clog2(HALF_CYC + 1);

    gen_state_t st, st_nx;
    logic [CW-1:0] cnt;
    logic start_pend, stop_pend, sda_dat;
    logic half_done, line_taken, in_xfer;

    assign half_done  = (cnt == CW'(HALF_CYC - 1));
    assign line_taken = bus_busy || (st != ST_IDLE);
    assign in_xfer    = (st == ST_START) || (st == ST_LOW) || (st == ST_HIGH);

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:    if (start_pend && !bus_busy) st_nx = ST_START;
            ST_START:   if (half_done) st_nx = ST_LOW;
            ST_LOW:     if (half_done) st_nx = stop_pend ? ST_STOP_LO : ST_HIGH;
            ST_HIGH:    if (half_done) st_nx = ST_LOW;
            ST_STOP_LO: if (half_done) st_nx = ST_STOP_HI;
            ST_STOP_HI: if (half_done) st_nx = ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else if (!enable) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= (st_nx != st) ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_pend <= 1'b0;
            stop_pend  <= 1'b0;
            start_fail <= 1'b0;
            sda_dat    <= 1'b0;
        end else if (!enable) begin
            start_pend <= 1'b0;
            stop_pend  <= 1'b0;
            start_fail <= 1'b0;
            sda_dat    <= 1'b0;
        end else begin
            if (st == ST_IDLE && st_nx == ST_START) start_pend <= 1'b0;
            if (fail_clr) start_fail <= 1'b0;
            if (start_req) begin
                if (line_taken && resv_dis) start_fail <= 1'b1;
                else                        start_pend <= 1'b1;
            end

            if (st_nx == ST_STOP_LO)      stop_pend <= 1'b0;
            else if (stop_req && in_xfer) stop_pend <= 1'b1;

            if (st_nx == ST_START)
                sda_dat <= 1'b1;
            else if (st == ST_LOW && cnt == CW'(HOLD_CYC - 1))
                sda_dat <= ~tx_bit;
        end
    end

    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (st)
            ST_IDLE:    begin scl_oe = 1'b0; sda_oe = 1'b0;    end
            ST_START:   begin scl_oe = 1'b0; sda_oe = 1'b1;    end
            ST_LOW:     begin scl_oe = 1'b1; sda_oe = sda_dat; end
            ST_HIGH:    begin scl_oe = 1'b0; sda_oe = sda_dat; end
            ST_STOP_LO: begin scl_oe = 1'b1; sda_oe = 1'b1;    end
            ST_STOP_HI: begin scl_oe = 1'b0; sda_oe = 1'b1;    end
            default:    begin scl_oe = 1'b0; sda_oe = 1'b0;    end
        endcase
    end

    assert_hold_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |=> $stable(sda_oe));
    assert_reject_sets_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start_req && resv_dis && bus_busy) |=> start_fail);
    assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start_fail && !fail_clr) |=> start_fail);
    assert_start_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && st_nx == ST_START) |=> (sda_oe && !scl_oe));
endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl #(
    parameter int HALF_CYC  = 10,
    parameter int HOLD_CYC  = 3,
    parameter int BYTE_CLKS = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_in,
    input  logic sda_in,
    input  logic start_req,
    input  logic stop_req,
    input  logic resv_dis,
    input  logic bus_init,
    input  logic irq_ninth,
    input  logic stop_irq_en,
    input  logic fail_clr,
    input  logic tx_bit,
    output logic scl_oe,
    output logic sda_oe,
    output logic bus_busy,
    output logic start_fail,
    output logic irq
);
    logic start_det, stop_det, scl_rise, scl_fall;

    i2c_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    i2c_bus_track #(.BYTE_CLKS(BYTE_CLKS)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .bus_init    (bus_init),
        .irq_ninth   (irq_ninth),
        .stop_irq_en (stop_irq_en),
        .bus_busy    (bus_busy),
        .irq         (irq)
    );

    i2c_cond_gen #(.HALF_CYC(HALF_CYC), .HOLD_CYC(HOLD_CYC)) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .resv_dis   (resv_dis),
        .bus_busy   (bus_busy),
        .fail_clr   (fail_clr),
        .tx_bit     (tx_bit),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .start_fail (start_fail)
    );

    assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_oe && !sda_oe && !bus_busy && !start_fail && !irq));
endmodule

// File: tb/sim_i2c_cond_ctrl.sv
module sim_i2c_cond_ctrl;
    localparam int HALF = 10;
    localparam int HOLD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, start_req = 1'b0, stop_req = 1'b0, resv_dis = 1'b0;
    logic bus_init = 1'b0, irq_ninth = 1'b0, stop_irq_en = 1'b0, fail_clr = 1'b0;
    logic tx_bit = 1'b1;
    logic ext_scl = 1'b1, ext_sda = 1'b1;
    logic scl_oe, sda_oe, bus_busy, start_fail, irq;
    wire  scl_in = ext_scl & ~scl_oe;
    wire  sda_in = ext_sda & ~sda_oe;

    always #4 clk = ~clk;

    i2c_cond_ctrl #(.HALF_CYC(HALF), .HOLD_CYC(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in), .sda_in(sda_in),
        .start_req(start_req), .stop_req(stop_req), .resv_dis(resv_dis),
        .bus_init(bus_init), .irq_ninth(irq_ninth), .stop_irq_en(stop_irq_en),
        .fail_clr(fail_clr), .tx_bit(tx_bit), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .bus_busy(bus_busy), .start_fail(start_fail), .irq(irq)
    );

    int checks = 0, errors = 0, cyc = 0, irq_seen = 0;
    int exp_q[$];
    int bc = 0, lastfall = 0, stop_recent = 0, kind = 0, expv = 0;
    logic pscl = 1'b1, psda = 1'b1, pirq = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops expected interrupt kinds (8, 9 = clock number, 100 = stop)
    always @(negedge clk) begin
        cyc++;
        if (pscl && scl_in && psda && !sda_in) bc = 0;
        if (pscl && scl_in && !psda && sda_in) stop_recent = 8;
        else if (stop_recent > 0) stop_recent--;
        if (!pscl && scl_in) bc++;
        if (pscl && !scl_in) begin
            lastfall = bc;
            if (bc == 9) bc = 0;
        end
        if (irq === 1'b1) begin
            irq_seen++;
            chk(!pirq, "R11 irq longer than one cycle", 1, 0);
            kind = (stop_recent > 0) ? 100 : lastfall;
            if (exp_q.size() == 0) chk(1'b0, "R8 R9 unexpected irq", kind, -1);
            else begin
                expv = exp_q.pop_front();
                chk(kind == expv, (expv == 100) ? "R9 stop irq" : "R8 clock irq", kind, expv);
            end
        end
        pirq = irq; pscl = scl_in; psda = sda_in;
        if (cyc > 150000 && !finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // which: 0 sda_oe, 1 scl_oe; returns cycles waited (-1 on timeout)
    task automatic wait_sig(input int which, input logic val, output int waited);
        waited = -1;
        for (int i = 0; i < 400; i++) begin
            if (((which == 0) ? sda_oe : scl_oe) === val) begin waited = i; break; end
            @(negedge clk);
        end
    endtask

    task automatic wait_q_empty();
        for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
    endtask

    task automatic pulse_start(); start_req = 1'b1; @(negedge clk); start_req = 1'b0; endtask
    task automatic pulse_stop();  stop_req  = 1'b1; @(negedge clk); stop_req  = 1'b0; endtask

    task automatic ext_start();
        ext_sda = 1'b0; tick(10); ext_scl = 1'b0; tick(10);
    endtask
    task automatic ext_stop();
        ext_scl = 1'b1; tick(10); ext_sda = 1'b1; tick(10);
    endtask

    int w;
    bit drove;

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk(scl_oe == 0, "R1 scl_oe at reset", scl_oe, 0);
        chk(sda_oe == 0, "R1 sda_oe at reset", sda_oe, 0);
        chk(bus_busy == 0, "R1 busy at reset", bus_busy, 0);
        chk(start_fail == 0, "R1 fail at reset", start_fail, 0);
        chk(irq == 0, "R1 irq at reset", irq, 0);
        enable = 1'b1; stop_irq_en = 1'b1; irq_ninth = 1'b0;
        tick(5);

        // Transfer A: 8th-clock irq, then 9th, then stop irq
        exp_q.push_back(8);
        pulse_start();
        wait_sig(0, 1'b1, w);
        chk(w >= 0 && scl_oe == 0, "R2 SDA low while SCL released", scl_oe, 0);
        wait_sig(1, 1'b1, w);
        chk(w == HALF, "R2 SCL low one half period after SDA", w, HALF);
        chk(sda_oe == 1, "R2 SDA still low when SCL pulled", sda_oe, 1);
        wait_sig(0, 1'b0, w);
        chk(w == HOLD, "R10 SDA change after hold count", w, HOLD);
        chk(bus_busy == 1, "R4 busy after own start", bus_busy, 1);
        wait_q_empty();
        irq_ninth = 1'b1;
        exp_q.push_back(9);
        wait_q_empty();
        exp_q.push_back(100);
        pulse_stop();
        for (int i = 0; i < 400 && !(scl_oe == 0 && sda_oe == 1); i++) @(negedge clk);
        chk(scl_oe == 0 && sda_oe == 1, "R3 SCL released with SDA low", sda_oe, 1);
        wait_sig(0, 1'b0, w);
        chk(w == HALF && scl_oe == 0, "R3 SDA released while SCL released", w, HALF);
        wait_q_empty();
        tick(3);
        chk(bus_busy == 0, "R4 busy cleared after stop", bus_busy, 0);

        // Transfer B: stop irq disabled
        stop_irq_en = 1'b0;
        exp_q.push_back(9);
        pulse_start();
        wait_q_empty();
        w = irq_seen;
        pulse_stop();
        tick(6 * HALF);
        chk(irq_seen == w, "R9 no irq on stop when disabled", irq_seen - w, 0);
        chk(bus_busy == 0, "R4 busy cleared after second stop", bus_busy, 0);

        // R5: external start, then bus_init
        ext_start();
        chk(bus_busy == 1, "R4 busy after external start", bus_busy, 1);
        bus_init = 1'b1; @(negedge clk); bus_init = 1'b0;
        tick(1);
        chk(bus_busy == 0, "R5 busy cleared by init", bus_busy, 0);
        ext_stop();

        // R6: reservation disabled, bus busy -> rejected and sticky
        resv_dis = 1'b1;
        ext_start();
        pulse_start();
        drove = 1'b0;
        for (int i = 0; i < 40; i++) begin if (scl_oe || sda_oe) drove = 1'b1; @(negedge clk); end
        chk(start_fail == 1, "R6 fail flag set", start_fail, 1);
        ext_stop();
        for (int i = 0; i < 60; i++) begin if (scl_oe || sda_oe) drove = 1'b1; @(negedge clk); end
        chk(!drove, "R6 rejected start never issued", drove, 0);
        chk(start_fail == 1, "R6 fail flag sticky", start_fail, 1);
        fail_clr = 1'b1; @(negedge clk); fail_clr = 1'b0;
        tick(1);
        chk(start_fail == 0, "R6 fail cleared by strobe", start_fail, 0);

        // R7: reservation enabled -> start deferred until stop
        resv_dis = 1'b0; stop_irq_en = 1'b1;
        ext_start();
        pulse_start();
        drove = 1'b0;
        for (int i = 0; i < 40; i++) begin if (scl_oe || sda_oe) drove = 1'b1; @(negedge clk); end
        chk(!drove, "R7 no start while bus busy", drove, 0);
        exp_q.push_back(100);
        exp_q.push_back(9);
        ext_scl = 1'b1; tick(10); ext_sda = 1'b1;
        wait_sig(0, 1'b1, w);
        chk(w >= 0 && scl_oe == 0, "R7 deferred start issued after stop", w >= 0, 1);
        wait_q_empty();
        exp_q.push_back(100);
        pulse_stop();
        wait_q_empty();
        tick(20);

        // R1: disable mid transfer
        pulse_start();
        tick(20);
        enable = 1'b0;
        tick(1);
        chk(scl_oe == 0 && sda_oe == 0, "R1 lines released when disabled", {scl_oe, sda_oe}, 0);
        chk(bus_busy == 0 && start_fail == 0, "R1 flags cleared when disabled", bus_busy, 0);
        tick(10);
        chk(exp_q.size() == 0, "R8 all expected interrupts seen", exp_q.size(), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule